// File: doc/BRIEF.md
# Floating-Point Issue Overlap Arbiter

This block sits at the issue point of a floating-point coprocessor. It decides whether an incoming instruction may start while the previous instruction is still running. It keeps one small piece of state: a busy flag and the index of the data register that the in-flight instruction will write. From that state and from the qualifiers of the incoming instruction, it grants one of three overlap levels and raises a stall when the instruction may not start yet.

Only register moves can be granted full overlap. A move loses full overlap, and drops back to partial, when any of the following holds:

- its source register is the in-flight destination;
- its destination register is the in-flight destination;
- an operand is a NaN, unnormalized or denormalized value;
- rounding precision is reduced to single or double;
- the inexact trap is enabled;
- the operation overflows or underflows.

Other floating-format operations always get partial overlap. Operations in non-floating formats get minimum overlap and wait until the unit is idle.

Top module: `fpu_overlap_arbiter`

## Requirements
- R1: After reset the unit is idle. With `issue_valid` low, `grant` is 2'b00 and `stall` is 0.
- R2: The `grant` encoding is 2'b00 minimum, 2'b01 partial and 2'b10 full. An `issue_kind` of 2'b00 (move) with no conflict and no qualifier set gets 2'b10.
- R3: While busy, a move whose source is a register (`src_is_reg`=1) equal to the tracked destination gets partial (2'b01).
- R4: While busy, a move whose destination is a register (`dst_is_reg`=1) equal to the tracked destination gets partial (2'b01).
- R5: Register equality causes no conflict when the unit is idle, or when the matching operand is not a register.
- R6: A move with `opnd_special`=1 (NaN, unnormalized or denormalized operand) gets partial.
- R7: A move with `prec_reduced`=1 (single or double rounding precision) gets partial.
- R8: A move with `inex_trap_en`=1 or `range_exc`=1 (overflow or underflow) gets partial.
- R9: `issue_kind` 2'b01 (floating-format arithmetic) always gets partial (2'b01).
- R10: `issue_kind` 2'b10 or 2'b11 (non-floating format) gets minimum (2'b00). `stall` is 1 exactly when such an instruction is valid while the unit is busy.
- R11: A valid instruction that is not stalled is accepted at the clock edge. The unit becomes busy, tracking that instruction's destination. `done` clears busy at the edge unless an instruction is accepted in the same cycle; in that case the new instruction becomes the one in flight.
- R12: A stalled instruction is not accepted and leaves the tracked destination unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| issue_kind | input | 2 | 00 move, 01 floating-format arithmetic, 1x non-floating format |
| src_is_reg | input | 1 | Source operand is a data register |
| src_idx | input | 3 | Source register index |
| dst_is_reg | input | 1 | Destination is a data register |
| dst_idx | input | 3 | Destination register index |
| opnd_special | input | 1 | Operand is NaN, unnormalized or denormalized |
| prec_reduced | input | 1 | Rounding precision set to single or double |
| inex_trap_en | input | 1 | Inexact exception trap enabled |
| range_exc | input | 1 | Overflow or underflow occurs |
| done | input | 1 | In-flight instruction completes |
| grant | output | 2 | Overlap level granted |
| stall | output | 1 | Instruction must wait |

## Verification
The bench covers these corner cases:

- **Source and destination conflicts, tested separately.** A design that compared only one of the two would grant full overlap to a move that reads or overwrites the pending result.
- **Equal indices where no conflict exists.** The bench repeats equal indices while the unit is idle and with a non-register operand. A design that skipped the busy or register qualifiers would demote these moves needlessly.
- **A non-floating instruction stalled while busy.** The bench then probes with moves to show the tracked destination did not move. A design that latched stalled instructions would shift the conflict to the wrong register.
- **Completion and a new acceptance in the same cycle.** A design that let `done` win would drop the new instruction's destination and miss its conflicts.

// File: rtl/fpu_overlap_arbiter.sv
module fpu_overlap_arbiter #(
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    issue_valid,
  input  logic [1:0]              issue_kind,
  input  logic                    src_is_reg,
  input  logic [$clog2(NREG)-1:0] src_idx,
  input  logic                    dst_is_reg,
  input  logic [$clog2(NREG)-1:0] dst_idx,
  input  logic                    opnd_special,
  input  logic                    prec_reduced,
  input  logic                    inex_trap_en,
  input  logic                    range_exc,
  input  logic                    done,
  output logic [1:0]              grant,
  output logic                    stall
);
  localparam int IW = $clog2(NREG);
  localparam logic [1:0] G_MIN  = 2'b00;
  localparam logic [1:0] G_PART = 2'b01;
  localparam logic [1:0] G_FULL = 2'b10;

  logic          busy_q;
  logic          has_dst_q;
  logic [IW-1:0] dst_q;

  wire live     = busy_q && has_dst_q;
  wire src_hit  = live && src_is_reg && (src_idx == dst_q);
  wire dst_hit  = live && dst_is_reg && (dst_idx == dst_q);
  wire mode_bad = opnd_special || prec_reduced || inex_trap_en || range_exc;
  wire is_move  = (issue_kind == 2'b00);
  wire is_min   = issue_kind[1];
  wire accept   = issue_valid && !stall;

  always_comb begin
    if (!issue_valid || is_min)
      grant = G_MIN;
    else if (is_move && !src_hit && !dst_hit && !mode_bad)
      grant = G_FULL;
    else
      grant = G_PART;
  end

  assign stall = issue_valid && is_min && busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      has_dst_q <= 1'b0;
      dst_q     <= '0;
    end else if (accept) begin
      busy_q    <= 1'b1;
      has_dst_q <= dst_is_reg;
      dst_q     <= dst_idx;
    end else if (done) begin
      busy_q    <= 1'b0;
    end
  end
endmodule

// File: rtl/fpu_overlap_arbiter_chk.sv
module fpu_overlap_arbiter_chk #(
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          issue_valid,
  input logic [1:0]    issue_kind,
  input logic          src_is_reg,
  input logic [IW-1:0] src_idx,
  input logic          dst_is_reg,
  input logic [IW-1:0] dst_idx,
  input logic          opnd_special,
  input logic          done,
  input logic [1:0]    grant,
  input logic          stall,
  input logic          busy_q,
  input logic          has_dst_q,
  input logic [IW-1:0] dst_q
);
  assert_full_only_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant == 2'b10 |-> issue_kind == 2'b00 && issue_valid);
  assert_src_conflict_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && busy_q && has_dst_q && src_is_reg && src_idx == dst_q |-> grant != 2'b10);
  assert_dst_conflict_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && busy_q && has_dst_q && dst_is_reg && dst_idx == dst_q |-> grant != 2'b10);
  assert_special_R6: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && opnd_special |-> grant != 2'b10);
  assert_stall_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> busy_q && issue_kind[1] && grant == 2'b00);
  assert_busy_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && !stall |=> busy_q);
  assert_done_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done && !(issue_valid && !stall) |=> !busy_q);
  assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(dst_q));
endmodule

bind fpu_overlap_arbiter fpu_overlap_arbiter_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_kind(issue_kind),
  .src_is_reg(src_is_reg), .src_idx(src_idx), .dst_is_reg(dst_is_reg),
  .dst_idx(dst_idx), .opnd_special(opnd_special), .done(done),
  .grant(grant), .stall(stall), .busy_q(busy_q), .has_dst_q(has_dst_q), .dst_q(dst_q)
);

// File: tb/fpu_overlap_arbiter_bench.sv
module fpu_overlap_arbiter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_valid = 1'b0;
  logic [1:0] issue_kind = 2'b00;
  logic src_is_reg = 1'b0;
  logic [2:0] src_idx = '0;
  logic dst_is_reg = 1'b0;
  logic [2:0] dst_idx = '0;
  logic opnd_special = 1'b0, prec_reduced = 1'b0, inex_trap_en = 1'b0, range_exc = 1'b0;
  logic done = 1'b0;
  logic [1:0] grant;
  logic stall;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fpu_overlap_arbiter u_fpu_overlap_arbiter (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_kind(issue_kind),
    .src_is_reg(src_is_reg), .src_idx(src_idx), .dst_is_reg(dst_is_reg), .dst_idx(dst_idx),
    .opnd_special(opnd_special), .prec_reduced(prec_reduced), .inex_trap_en(inex_trap_en),
    .range_exc(range_exc), .done(done), .grant(grant), .stall(stall));

  task automatic check(input string req, input logic [1:0] g_exp, input logic s_exp);
    checks++;
    if (grant !== g_exp || stall !== s_exp) begin
      fails++;
      $display("FAIL %s: grant=%b stall=%b expected grant=%b stall=%b", req, grant, stall, g_exp, s_exp);
    end
  endtask

  task automatic present(input logic [1:0] k, input logic sr, input logic [2:0] s,
                         input logic dr, input logic [2:0] d, input logic [3:0] q);
    issue_valid = 1'b1; issue_kind = k;
    src_is_reg = sr; src_idx = s; dst_is_reg = dr; dst_idx = d;
    {opnd_special, prec_reduced, inex_trap_en, range_exc} = q;
  endtask

  task automatic idle_in();
    issue_valid = 1'b0; done = 1'b0;
    {opnd_special, prec_reduced, inex_trap_en, range_exc} = 4'b0;
  endtask

  // combinational look, withdrawn before the next edge
  task automatic probe(input string req, input logic [1:0] k, input logic sr, input logic [2:0] s,
                       input logic dr, input logic [2:0] d, input logic [3:0] q,
                       input logic [1:0] g_exp, input logic s_exp);
    @(negedge clk);
    present(k, sr, s, dr, d, q);
    #1 check(req, g_exp, s_exp);
    #1 idle_in();
  endtask

  // held across one edge so it is accepted unless stalled
  task automatic commit(input string req, input logic [1:0] k, input logic [2:0] d, input logic dn,
                        input logic [1:0] g_exp, input logic s_exp);
    @(negedge clk);
    present(k, 1'b0, 3'd0, 1'b1, d, 4'b0);
    done = dn;
    #1 check(req, g_exp, s_exp);
    @(negedge clk);
    idle_in();
  endtask

  task automatic t_reset();
    @(negedge clk);
    #1 check("R1", 2'b00, 1'b0);
    probe("R1 R5", 2'b00, 1'b1, 3'd3, 1'b1, 3'd3, 4'b0, 2'b10, 1'b0);
  endtask

  task automatic t_conflicts();
    commit("R9", 2'b01, 3'd4, 1'b0, 2'b01, 1'b0);
    probe("R3", 2'b00, 1'b1, 3'd4, 1'b1, 3'd1, 4'b0, 2'b01, 1'b0);
    probe("R4", 2'b00, 1'b1, 3'd1, 1'b1, 3'd4, 4'b0, 2'b01, 1'b0);
    probe("R5", 2'b00, 1'b0, 3'd4, 1'b1, 3'd1, 4'b0, 2'b10, 1'b0);
    probe("R5", 2'b00, 1'b1, 3'd1, 1'b0, 3'd4, 4'b0, 2'b10, 1'b0);
    probe("R2", 2'b00, 1'b1, 3'd1, 1'b1, 3'd5, 4'b0, 2'b10, 1'b0);
    probe("R9", 2'b01, 1'b1, 3'd1, 1'b1, 3'd5, 4'b0, 2'b01, 1'b0);
  endtask

  task automatic t_qualifiers();
    probe("R6", 2'b00, 1'b1, 3'd1, 1'b1, 3'd5, 4'b1000, 2'b01, 1'b0);
    probe("R7", 2'b00, 1'b1, 3'd1, 1'b1, 3'd5, 4'b0100, 2'b01, 1'b0);
    probe("R8", 2'b00, 1'b1, 3'd1, 1'b1, 3'd5, 4'b0010, 2'b01, 1'b0);
    probe("R8", 2'b00, 1'b1, 3'd1, 1'b1, 3'd5, 4'b0001, 2'b01, 1'b0);
  endtask

  task automatic t_minimum();
    probe("R10", 2'b10, 1'b0, 3'd0, 1'b1, 3'd7, 4'b0, 2'b00, 1'b1);
    probe("R10", 2'b11, 1'b0, 3'd0, 1'b1, 3'd7, 4'b0, 2'b00, 1'b1);
    commit("R10", 2'b10, 3'd7, 1'b0, 2'b00, 1'b1);
    probe("R12", 2'b00, 1'b1, 3'd7, 1'b1, 3'd0, 4'b0, 2'b10, 1'b0);
    probe("R12", 2'b00, 1'b1, 3'd4, 1'b1, 3'd0, 4'b0, 2'b01, 1'b0);
  endtask

  task automatic t_complete();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
    probe("R11", 2'b00, 1'b1, 3'd4, 1'b1, 3'd4, 4'b0, 2'b10, 1'b0);
    probe("R10", 2'b10, 1'b0, 3'd0, 1'b1, 3'd4, 4'b0, 2'b00, 1'b0);
    commit("R11", 2'b00, 3'd6, 1'b0, 2'b10, 1'b0);
    probe("R11", 2'b00, 1'b1, 3'd6, 1'b1, 3'd0, 4'b0, 2'b01, 1'b0);
    commit("R11", 2'b01, 3'd2, 1'b1, 2'b01, 1'b0);
    probe("R11", 2'b00, 1'b1, 3'd2, 1'b1, 3'd0, 4'b0, 2'b01, 1'b0);
    probe("R11", 2'b00, 1'b1, 3'd6, 1'b1, 3'd0, 4'b0, 2'b10, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_conflicts();
    t_qualifiers();
    t_minimum();
    t_complete();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule